// File: doc/BRIEF.md
# Transmitter Disable and Status/Control Byte

This block holds the single status and control byte that a transceiver's diagnostic register space exposes at offset 110. The byte sits next to the logic that decides whether the optical transmitter may emit light. The transmitter is switched off by either of two sources: the external disable pin, where 1 means disable, or a soft disable bit that software writes through the register port. Both pin-level inputs, the disable pin and the receive signal-detect indication, pass through a reset-preset synchronizer before they are used. During reset the block comes up in the fail-safe state, with the transmitter off and the signal reported as absent.

Each bit of the byte has its own access rule. Some bits mirror synchronized pins. One bit is writable: it is stored and read back but has no other effect. Three bits are fixed constants that ignore writes. The lowest bit is an active-low data-ready flag. A two-state power-up sequencer drives this flag. After reset the sequencer starts in `PWR_WAIT` and counts system clock cycles. It moves to `PWR_READY` when the count reaches `PWRUP_CYCLES`, and it stays in `PWR_READY` until the next reset.

A write applies only when the write strobe and the offset-110 select are both high. The read-back value is always available on `rd_data`.

Top module: `tdc_status_ctrl`

## Requirements
- R1: `tx_disable` is 1 whenever the synchronized disable pin is 1 or the soft disable bit (bit 6) is 1, and it is 0 only when both are 0.
- R2: Bit 7 reads the disable pin state (1 = disable asserted). A pin change reaches bit 7 and `tx_disable` after exactly `SYNC_STAGES` rising clock edges.
- R3: Bit 6 is read/write. A write with `wr_en` and `wr_sel` both high stores `wr_data[6]`, and the new value is visible after the next rising edge.
- R4: The fixed bits always read as follows, whatever is written: bit 5 reads 0, bit 4 reads 1 and bit 2 reads 0.
- R5: Bit 3 stores `wr_data[3]` on a selected write and reads it back. It has no effect on `tx_disable`.
- R6: Bit 1 reads the inverse of the synchronized `sig_detect` input, so that 0 means a signal is detected.
- R7: Bit 0 reads 1 for the first `PWRUP_CYCLES` rising edges after reset is released (state `PWR_WAIT`). After that it reads 0 (state `PWR_READY`) and stays 0 until the next reset.
- R8: A write with `wr_en` high but `wr_sel` low changes no bit of the byte.
- R9: While `rst_n` is low, bits 6 and 3 clear to 0, the pin synchronizers preset to "disabled" and "no signal", and the byte reads 0x93 with `tx_disable` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_pin | input | 1 | External transmitter disable pin, 1 = disable |
| sig_detect | input | 1 | Receive signal detect, 1 = optical signal present |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Offset-110 select for the write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read-back value of the status/control byte |
| tx_disable | output | 1 | Effective transmitter disable |

## Verification
The bench builds the block with `PWRUP_CYCLES` = 20 and `SYNC_STAGES` = 2. With these values the `PWR_WAIT` to `PWR_READY` transition can be checked on the exact edge: bit 0 is checked one cycle before the terminal count and again on it. The short synchronizer lets the bench check the pin-to-output latency one edge early and on time. The default delay corresponds to 100 ms at 100 MHz, which is well within the one-second limit for data ready.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    // Power-up sequencer states
    typedef enum logic [0:0] {
        PWR_WAIT  = 1'b0,
        PWR_READY = 1'b1
    } pwr_state_e;

    // Bit positions inside the status/control byte (decoded by software)
    localparam int unsigned BIT_PIN_STATE  = 7;
    localparam int unsigned BIT_SOFT_DIS   = 6;
    localparam int unsigned BIT_RSVD       = 5;
    localparam int unsigned BIT_FIXED_ONE  = 4;
    localparam int unsigned BIT_SCRATCH    = 3;
    localparam int unsigned BIT_FIXED_ZERO = 2;
    localparam int unsigned BIT_SD_STATE   = 1;
    localparam int unsigned BIT_RDY_N      = 0;

endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/tdc_pwrup_fsm.sv
module tdc_pwrup_fsm
    import tdc_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic rdy_n
);

    localparam int unsigned CW = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES - 1);

    pwr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_WAIT;
        else        state_q <= state_d;
    end

    // cycle counter, only runs while waiting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (state_q == PWR_WAIT && !at_last)   cnt_q <= cnt_q + 1'b1;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        rdy_n   = 1'b1;
        unique case (state_q)
            PWR_WAIT: begin
                rdy_n = 1'b1;
                if (at_last) state_d = PWR_READY;
            end
            PWR_READY: begin
                rdy_n = 1'b0;
            end
            default: begin
                rdy_n   = 1'b1;
                state_d = PWR_WAIT;
            end
        endcase
    end

endmodule

// File: rtl/tdc_ctrl_reg.sv
module tdc_ctrl_reg
    import tdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       soft_dis,
    output logic       scratch
);

    logic wr_hit;
    assign wr_hit = wr_en && wr_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_dis <= 1'b0;
            scratch  <= 1'b0;
        end else if (wr_hit) begin
            soft_dis <= wr_data[BIT_SOFT_DIS];
            scratch  <= wr_data[BIT_SCRATCH];
        end
    end

endmodule

// File: rtl/tdc_status_ctrl.sv
module tdc_status_ctrl
    import tdc_pkg::*;
#(
    parameter int unsigned PWRUP_CYCLES = 10_000_000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dis_pin,
    input  logic       sig_detect,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       tx_disable
);

    logic pin_s, sd_s, rdy_n, soft_dis, scratch;

    // pin synchronizer presets to "disabled", like an undriven pulled-up pin
    tdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_in(dis_pin), .q_out(pin_s)
    );

    tdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd_sync (
        .clk(clk), .rst_n(rst_n), .d_in(sig_detect), .q_out(sd_s)
    );

    tdc_pwrup_fsm #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwrup (
        .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n)
    );

    tdc_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .soft_dis(soft_dis), .scratch(scratch)
    );

    assign tx_disable = pin_s | soft_dis;

    always_comb begin
        rd_data                 = '0;
        rd_data[BIT_PIN_STATE]  = pin_s;
        rd_data[BIT_SOFT_DIS]   = soft_dis;
        rd_data[BIT_RSVD]       = 1'b0;
        rd_data[BIT_FIXED_ONE]  = 1'b1;
        rd_data[BIT_SCRATCH]    = scratch;
        rd_data[BIT_FIXED_ZERO] = 1'b0;
        rd_data[BIT_SD_STATE]   = ~sd_s;
        rd_data[BIT_RDY_N]      = rdy_n;
    end

endmodule

// File: rtl/tdc_status_ctrl_chk.sv
module tdc_status_ctrl_chk #(
    parameter int unsigned PWRUP_CYCLES = 10_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       tx_disable
);

    localparam int unsigned CW = $clog2(PWRUP_CYCLES + 1) + 1;
    localparam logic [CW-1:0] LIM = CW'(PWRUP_CYCLES);

    logic [CW-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst < LIM) since_rst <= since_rst + 1'b1;
    end

    // R1
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] || rd_data[6]) |-> tx_disable);

    // R1
    tx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !rd_data[6]) |-> !tx_disable);

    // R3
    soft_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (rd_data[6] == $past(wr_data[6]) && rd_data[3] == $past(wr_data[3])));

    // R8
    no_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel) |=> ($stable(rd_data[6]) && $stable(rd_data[3])));

    // R4
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5:4] == 2'b01) && !rd_data[2]);

    // R7
    rdy_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> (since_rst >= LIM));

    // R7
    rdy_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LIM) |-> !rd_data[0]);

endmodule

bind tdc_status_ctrl tdc_status_ctrl_chk #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_data(rd_data), .tx_disable(tx_disable)
);

// File: tb/test_tdc_status_ctrl.sv
`timescale 1ns/1ps
module test_tdc_status_ctrl;

    localparam int unsigned PWRUP = 20;
    localparam int unsigned SYNC  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis_pin = 1'b0;
    logic       sig_detect = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       tx_disable;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tdc_status_ctrl #(.PWRUP_CYCLES(PWRUP), .SYNC_STAGES(SYNC)) i_tdc_status_ctrl (
        .clk(clk), .rst_n(rst_n), .dis_pin(dis_pin), .sig_detect(sig_detect),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .tx_disable(tx_disable)
    );

    // vector: {pin, sd, wr_en, wr_sel, wr_data[7:0], exp_rd[7:0], exp_dis}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h58, 1'b1},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hDA, 1'b1},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h40, 8'hD2, 1'b1},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'h08, 8'h1A, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h90, 1'b1},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'hB7, 8'h10, 1'b0},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h10, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic pulse_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 reset byte", rd_data, 8'h93);
        chk("R9 reset tx_disable", {7'b0, tx_disable}, 8'h01);

        // R7 power-up window, with pins quiet
        dis_pin = 1'b0; sig_detect = 1'b0;
        rst_n = 1'b1;
        repeat (PWRUP - 1) @(negedge clk);
        chk("R7 not ready before count", {7'b0, rd_data[0]}, 8'h01);
        chk("R6 no signal reads 1", {7'b0, rd_data[1]}, 8'h01);
        @(negedge clk);
        chk("R7 ready at count", {7'b0, rd_data[0]}, 8'h00);
        chk("R1 pin low soft low", {7'b0, tx_disable}, 8'h00);

        // table: R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            dis_pin = VEC[i][20]; sig_detect = VEC[i][19];
            wr_en = VEC[i][18]; wr_sel = VEC[i][17]; wr_data = VEC[i][16:9];
            @(negedge clk);
            wr_en = 1'b0; wr_sel = 1'b0;
            repeat (SYNC) @(negedge clk);
            chk($sformatf("R1-table byte vec %0d (R2 R3 R4 R5 R6 R8)", i), rd_data, VEC[i][8:1]);
            chk($sformatf("R1 table tx_disable vec %0d", i), {7'b0, tx_disable}, {7'b0, VEC[i][0]});
        end

        // R2 pin latency: exactly SYNC edges
        @(negedge clk);
        dis_pin = 1'b1;
        repeat (SYNC - 1) @(negedge clk);
        chk("R2 pin not yet seen", {7'b0, tx_disable}, 8'h00);
        @(negedge clk);
        chk("R2 pin seen after sync", {7'b0, tx_disable}, 8'h01);
        dis_pin = 1'b0;
        repeat (SYNC + 1) @(negedge clk);

        // R5 scratch bit alone leaves transmitter on
        pulse_write(8'h08);
        chk("R5 scratch no effect", {7'b0, tx_disable}, 8'h00);
        chk("R5 scratch read back", rd_data, 8'h18);

        // R3 soft bit takes effect one edge after write
        pulse_write(8'h40);
        chk("R3 soft disable", {7'b0, tx_disable}, 8'h01);

        // R9 reset mid-operation clears soft and scratch, ready bit returns
        pulse_write(8'h48);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset again", rd_data, 8'h93);
        rst_n = 1'b1;
        repeat (PWRUP + 1) @(negedge clk);
        chk("R9 cleared after reset, R7 ready", rd_data, 8'h10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule